// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Selectable Deselect Timing

This block is a synthesizable behavioural model of a pipelined synchronous static RAM. The word is built from byte lanes, four lanes of nine bits by default. Address, chip enable and the write controls are captured on the rising clock edge. A captured read delivers its word from an output register one edge later. Writes are self-timed and land in the array on the same edge that captures them. A write can cover the whole word or only the lanes picked by a per-lane select vector.

The read data bus has a separate driver-enable output, so a pad ring or a bus model can tristate it. A static mode input picks how long the bus keeps driving after the part is deselected. In the short mode the enable drops one edge after the deselect is captured. In the long mode the last word stays on the bus for one more cycle. An output-enable input and a sleep input act without the clock. Sleep also blocks new commands, and the array keeps its contents while asleep.

A two-flop synchronizer releases the asynchronous active-low reset into the clock domain. After reset, the bench waits three edges before it issues the first command.

Top module: `sync_sram_pipe`

## Requirements
- R1: While reset is held, and after it is released with no read issued, `drv_en` is 0.
- R2: A read captured at edge k (`ce`=1, `gwe`=0, `bwe`=0, `sleep`=0) puts the stored word on `rdata` after edge k+1. With `oe`=1 and `sleep`=0, `drv_en` is 1 for that cycle. Back-to-back reads return one word per cycle.
- R3: A write with `gwe`=1 and `ce`=1 stores all of `wdata`, whatever the values of `bwe` and `bsel`.
- R4: With `gwe`=0 and `bwe`=1, lane i (bits [9i+8:9i]) is written only when `bsel[i]` is 1. The other lanes keep their old value. With `bsel`=0, no lane changes.
- R5: A read of an address captured on the edge after a write to it returns the newly written word.
- R6: With `dual_desel`=0, a deselect (`ce`=0) captured at edge j turns `drv_en` off after edge j+1.
- R7: With `dual_desel`=1, a deselect captured at edge j, directly after a read, keeps `drv_en` and the last word through the cycle after edge j+1. `drv_en` goes low after edge j+2.
- R8: `oe`=0 forces `drv_en` to 0 at once, without a clock edge. When `oe` returns to 1, the pending word is driven again, because the pipeline is not disturbed.
- R9: `sleep`=1 forces `drv_en` to 0 at once. Commands captured while `sleep`=1 neither write nor read. Stored data is kept across sleep.
- R10: A write command produces no drive. After a write captured at edge k, `drv_en` is 0 after edge k+1 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| ce | input | 1 | Chip enable, active high; low is a deselect |
| bwe | input | 1 | Lane-write enable |
| bsel | input | LANES | Per-lane write selects |
| gwe | input | 1 | Whole-word write, overrides `bwe`/`bsel` |
| wdata | input | LANES*LANE_W | Write data |
| dual_desel | input | 1 | 0: short deselect, 1: long deselect |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous low-power request, active high |
| rdata | output | LANES*LANE_W | Registered read data |
| drv_en | output | 1 | Read bus driver enable |

## Verification
A read result is due two edges after its command is presented: one edge captures the command and the next loads the output register. The bench therefore checks the word for command n right after it issues command n+1, at 1 ns past the edge. The end of drive after a deselect is due one edge after the deselect is captured in the short mode and two edges after in the long mode. The bench counts those edges explicitly. Effects of `oe` and `sleep` are checked within the same cycle, with no edge in between, since both act combinationally.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } sram_cmd_e;
endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_pipe_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce,
  input  logic             sleep,
  input  logic             bwe,
  input  logic             gwe,
  input  logic [LANES-1:0] bsel,
  output sram_cmd_e        cmd,
  output logic [LANES-1:0] wr_mask
);
  always_comb begin
    cmd = CMD_IDLE;
    if (ce && !sleep) begin
      if (gwe || bwe) cmd = CMD_WRITE;
      else            cmd = CMD_READ;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_mask[l] = (cmd == CMD_WRITE) && (gwe || bsel[l]);
  end
endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    logic [LANE_W-1:0] rd_d;

    always_ff @(posedge clk) begin
      if (wr_mask[l]) mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
    end

    always_comb rd_d = rd_en ? mem[rd_addr] : rd_q;

    always_ff @(posedge clk) begin
      rd_q <= rd_d;
    end

    assign rd_data[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram_drv_ctrl.sv
module sram_drv_ctrl
  import sram_pipe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sram_cmd_e cmd_q,
  input  logic      dual_desel,
  input  logic      oe,
  input  logic      sleep,
  output logic      drv_en
);
  logic rd_valid_q, rd_valid_d;
  logic ext_q, ext_d;
  logic hold;

  always_comb begin
    rd_valid_d = (cmd_q == CMD_READ);
    ext_d      = rd_valid_q && (cmd_q == CMD_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      ext_q      <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
      ext_q      <= ext_d;
    end
  end

  always_comb begin
    if (dual_desel) hold = rd_valid_q || ext_q;
    else            hold = rd_valid_q;
    drv_en = hold && oe && !sleep;
  end

  // R2
  read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_READ) |=> (drv_en || !oe || sleep));

  // R10
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WRITE) |=> !rd_valid_q);
endmodule

// File: rtl/sync_sram_pipe.sv
module sync_sram_pipe
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce,
  input  logic                    bwe,
  input  logic [LANES-1:0]        bsel,
  input  logic                    gwe,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    dual_desel,
  input  logic                    oe,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    drv_en
);
  logic              rst_n_s;
  sram_cmd_e         cmd_d, cmd_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [LANES-1:0]  wr_mask;

  sram_rst_sync i_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_s)
  );

  sram_cmd_decode #(.LANES(LANES)) i_decode (
    .ce      (ce),
    .sleep   (sleep),
    .bwe     (bwe),
    .gwe     (gwe),
    .bsel    (bsel),
    .cmd     (cmd_d),
    .wr_mask (wr_mask)
  );

  always_comb addr_d = (cmd_d == CMD_READ) ? addr : addr_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cmd_q  <= CMD_IDLE;
      addr_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
    end
  end

  sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_store (
    .clk     (clk),
    .wr_mask (wr_mask),
    .wr_addr (addr),
    .wr_data (wdata),
    .rd_en   (cmd_q == CMD_READ),
    .rd_addr (addr_q),
    .rd_data (rdata)
  );

  sram_drv_ctrl i_drv (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cmd_q      (cmd_q),
    .dual_desel (dual_desel),
    .oe         (oe),
    .sleep      (sleep),
    .drv_en     (drv_en)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n_s |-> !drv_en);

  // R3
  gw_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ce && gwe && !sleep) |-> (&wr_mask));

  // R4
  lane_subset_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ce && !gwe && !sleep) |-> ((wr_mask & ~bsel) == '0));

  // R9
  sleep_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    sleep |-> (wr_mask == '0));

  // R9
  sleep_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    sleep |-> !drv_en);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !oe |-> !drv_en);

  // R6
  scd_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!dual_desel && cmd_q == CMD_IDLE) |=> !drv_en);

  // R7
  dcd_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dual_desel && cmd_q == CMD_IDLE && $past(cmd_q == CMD_IDLE)) |=> !drv_en);
endmodule

// File: tb/test_sync_sram_pipe.sv
`timescale 1ns/1ps
module test_sync_sram_pipe;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        arst_n;
  logic [AW-1:0] addr;
  logic        ce, bwe, gwe, dual_desel, oe, sleep;
  logic [3:0]  bsel;
  logic [35:0] wdata;
  logic [35:0] rdata;
  logic        drv_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [35:0] model [NW];

  always #2.5 clk = ~clk;

  sync_sram_pipe i_sync_sram_pipe (
    .clk(clk), .arst_n(arst_n), .addr(addr), .ce(ce), .bwe(bwe), .bsel(bsel),
    .gwe(gwe), .wdata(wdata), .dual_desel(dual_desel), .oe(oe), .sleep(sleep),
    .rdata(rdata), .drv_en(drv_en)
  );

  function automatic logic [35:0] pat(input int a, input int salt);
    return (36'(a) * 36'd2654435 + 36'(salt) * 36'd77711) ^ 36'hA5A5A5A5A;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic c, input int a, input logic bw, input logic [3:0] bs,
                       input logic g, input logic [35:0] d);
    ce = c; addr = AW'(a); bwe = bw; bsel = bs; gwe = g; wdata = d;
    if (c && !sleep && (g || bw)) begin
      for (int l = 0; l < 4; l++)
        if (g || bs[l]) model[a][9*l +: 9] = d[9*l +: 9];
    end
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input int a);
    issue(1'b1, a, 1'b0, 4'h0, 1'b0, 36'h0);
  endtask

  task automatic idle();
    issue(1'b0, 0, 1'b0, 4'h0, 1'b0, 36'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; ce = 0; addr = '0; bwe = 0; bsel = 0; gwe = 0; wdata = '0;
    dual_desel = 0; oe = 1; sleep = 0;
    for (int i = 0; i < NW; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 drv_en in reset", 36'(drv_en), 36'd0);
    arst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 drv_en after release", 36'(drv_en), 36'd0);

    // R3: whole-word writes with arbitrary lane controls
    for (int a = 0; a < NW; a++)
      issue(1'b1, a, a[0], 4'(a), 1'b1, pat(a, 1));
    idle();

    // R2, R6, R7: pipelined read sweep in both modes
    for (int m = 0; m < 2; m++) begin
      dual_desel = m[0];
      idle(); idle();
      for (int i = 0; i <= NW; i++) begin
        if (i < NW) rd(i); else idle();
        if (i > 0) begin
          chk("R2/R3 read data", rdata, model[i-1]);
          chk("R2 drv_en on read", 36'(drv_en), 36'd1);
        end
      end
      idle();
      chk(m ? "R7 drv held one extra cycle" : "R6 drv off after deselect",
          36'(drv_en), 36'(m));
      idle();
      chk("R6/R7 drv finally off", 36'(drv_en), 36'd0);
    end
    dual_desel = 0;

    // R4: every lane-select value, bsel=0 included
    for (int a = 0; a < 16; a++)
      issue(1'b1, a, 1'b1, 4'(a), 1'b0, ~pat(a, 2));
    idle();
    for (int i = 0; i <= 16; i++) begin
      if (i < 16) rd(i); else idle();
      if (i > 0) chk("R4 lane write merge", rdata, model[i-1]);
    end
    idle(); idle();

    // R5: read directly after write
    issue(1'b1, 20, 1'b0, 4'h0, 1'b1, 36'h123456789);
    rd(20);
    idle();
    chk("R5 write then read", rdata, 36'h123456789);
    chk("R5 drv_en", 36'(drv_en), 36'd1);
    idle();

    // R10: write in both modes
    for (int m = 0; m < 2; m++) begin
      dual_desel = m[0];
      idle(); idle();
      rd(5);
      issue(1'b1, 6, 1'b0, 4'h0, 1'b1, pat(6, 3));
      chk("R10 prior read still driven", rdata, model[5]);
      idle();
      chk("R10 no drive after write", 36'(drv_en), 36'd0);
      idle();
    end

    // R6 vs R7: single read followed by deselect
    for (int m = 0; m < 2; m++) begin
      dual_desel = m[0];
      idle(); idle();
      rd(7);
      idle();
      chk("R6/R7 read word driven", rdata, model[7]);
      chk("R6/R7 drv after read", 36'(drv_en), 36'd1);
      idle();
      chk(m ? "R7 drv after second edge" : "R6 drv after first edge",
          36'(drv_en), 36'(m));
      if (m) chk("R7 word held", rdata, model[7]);
      idle();
      chk("R6/R7 drv off", 36'(drv_en), 36'd0);
    end
    dual_desel = 0;
    idle(); idle();

    // R8: asynchronous output enable
    rd(3);
    rd(3);
    oe = 1'b0;
    #1;
    chk("R8 oe low drops drive", 36'(drv_en), 36'd0);
    oe = 1'b1;
    #1;
    chk("R8 oe high restores drive", 36'(drv_en), 36'd1);
    chk("R8 pending word intact", rdata, model[3]);
    idle(); idle();

    // R9: sleep
    rd(9);
    rd(9);
    sleep = 1'b1;
    #1;
    chk("R9 sleep drops drive", 36'(drv_en), 36'd0);
    issue(1'b1, 9, 1'b0, 4'h0, 1'b1, 36'hFFFFFFFFF);
    issue(1'b1, 9, 1'b0, 4'h0, 1'b0, 36'h0);
    idle();
    chk("R9 no drive while asleep", 36'(drv_en), 36'd0);
    sleep = 1'b0;
    idle();
    chk("R9 command ignored in sleep", 36'(drv_en), 36'd0);
    rd(9);
    idle();
    chk("R9 data retained", rdata, model[9]);
    chk("R9 drive after wake", 36'(drv_en), 36'd1);
    idle(); idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule